// File: doc/BRIEF.md
# Delayed Multi-Unit Instruction Scheduler

This block sits beside a 32-lane vector unit made of five sub-units: load, simple, multiply-add, round and store. A macro load can leave behind at most one deferred instruction for each sub-unit, and each of those carries its own delay. The scheduler keeps one pending slot per sub-unit and runs its countdown. When the countdown expires it hands the deferred instruction to its sub-unit, in parallel with whatever the thread issues directly.

Each slot counts in one of two modes. In the first it counts clock cycles. In the second it counts only the cycles in which the thread reports an issued vector instruction. A deferred store always writes back to the address its macro loaded from. That address is captured when the macro is accepted.

These rules make a software-pipelined conditional select possible. In place, it takes three cycles per row, because the deferred store overlaps the next macro. Out of place, it takes four cycles per row, because the store must then be issued directly.

Top module: `macro_slot_sched`

## Requirements
- R1: After reset, with idle inputs, `unitFire`, `directStall` and `macroErr` are all zero.
- R2: A macro accepted in cycle c for a sub-unit, with delay d ≥ 1 and mode 0 (cycle counting), fires that sub-unit in cycle c+1+d and in no earlier cycle. The fire lasts one cycle, with `unitQueued`=1 and the op that the macro supplied.
- R3: A macro slot with delay 0 fires in cycle c+1 in either mode.
- R4: In mode 1 (issued counting), the countdown steps only at clock edges where `instrIssued` is 1. The edge that accepts the macro does not count. The slot fires in the cycle after the edge that brings the count from 1 to 0.
- R5: Sub-unit u uses bit u of `macroMask`, `macroModes`, `directValid` and of every strobe output. It uses bits [u*OP_W +: OP_W] of the op vectors and [u*DLY_W +: DLY_W] of `macroDelays`. The order is load=0, simple=1, multiply-add=2, round=3, store=4. Several slots armed by one macro count down and fire independently.
- R6: While a deferred store (sub-unit 4) fires, `storeAddr` equals the `macroAddr` that was presented when its macro was accepted. Later values on `macroAddr` or `directAddr` do not change it.
- R7: A macro that selects a slot which is pending and not firing raises `macroErr` in that same cycle. The request for that slot is dropped, and the earlier request fires unchanged. Slots of the same macro that are not busy are still accepted.
- R8: A slot in its firing cycle accepts a new macro without error, so the same sub-unit can fire again in the following cycle.
- R9: When a deferred instruction fires on a sub-unit that also has `directValid` set, the deferred op is issued and `directStall` for that sub-unit is 1 for that cycle.
- R10: A direct instruction on a sub-unit with no deferred fire is issued in the same cycle, with `unitQueued`=0 and no stall. A direct store drives `storeAddr` from `directAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| macroValid | input | 1 | Macro load presented this cycle |
| macroAddr | input | ADDR_W | Resolved address the macro loads from |
| macroMask | input | 5 | Sub-units that receive a deferred instruction |
| macroOps | input | 5*OP_W | Deferred op per sub-unit |
| macroDelays | input | 5*DLY_W | Delay per sub-unit |
| macroModes | input | 5 | Per sub-unit: 0 counts cycles, 1 counts issued instructions |
| instrIssued | input | 1 | Thread issued a vector instruction this cycle |
| directValid | input | 5 | Directly issued instruction per sub-unit |
| directOps | input | 5*OP_W | Direct op per sub-unit |
| directAddr | input | ADDR_W | Address for a direct store |
| unitFire | output | 5 | Issue strobe per sub-unit |
| unitOps | output | 5*OP_W | Op issued per sub-unit |
| unitQueued | output | 5 | Issued op came from a deferred slot |
| directStall | output | 5 | Direct instruction was held off by a deferred one |
| storeAddr | output | ADDR_W | Address for the store sub-unit |
| macroErr | output | 1 | Macro targeted a busy slot |

## Verification
A countdown that is off by one shows up at the ports directly. The fire strobe moves by one cycle, so each slot is checked in the exact cycle its delay predicts, and any early or extra strobe counts as a miscompare. A bad latch of the op or the address shows up only when the slot fires, which can be up to 2^DLY_W cycles later. The bench therefore changes `macroAddr` and `directAddr` between the moment a slot is armed and the moment it fires. A wrong busy state shows up in the same cycle as the next macro, either as a missing or spurious `macroErr`, or as a second fire that should never happen.

// File: rtl/msched_pkg.sv
package msched_pkg;
  localparam int NUM_UNITS = 5;

  typedef enum int unsigned {
    UNIT_LOAD   = 0,
    UNIT_SIMPLE = 1,
    UNIT_MAD    = 2,
    UNIT_ROUND  = 3,
    UNIT_STORE  = 4
  } unit_e;

  localparam int STORE_IDX = int'(UNIT_STORE);

  typedef enum logic {
    DLY_CYCLES = 1'b0,
    DLY_ISSUED = 1'b1
  } dly_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_UNITS-1:0] accept;
    logic [NUM_UNITS-1:0] fire;
  } slot_ctl_t;
endpackage

// File: rtl/msched_slot.sv
module msched_slot
  import msched_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DLY_W-1:0] delayIn,
  input  dly_mode_e        modeIn,
  input  logic             issuedTick,
  output logic             busy,
  output logic             pending,
  output logic             fire
);
  logic [DLY_W-1:0] cnt;
  logic             ready;
  dly_mode_e        mode;
  logic             stepNow;

  assign stepNow = pending && !ready && ((mode == DLY_CYCLES) || issuedTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      ready   <= 1'b0;
      cnt     <= '0;
      mode    <= DLY_CYCLES;
    end else if (load) begin
      pending <= 1'b1;
      cnt     <= delayIn;
      mode    <= modeIn;
      ready   <= (delayIn == '0);
    end else if (ready) begin
      pending <= 1'b0;
      ready   <= 1'b0;
    end else if (stepNow) begin
      cnt   <= cnt - 1'b1;
      ready <= (cnt == DLY_W'(1));
    end
  end

  assign fire = ready;
  assign busy = pending && !ready;
endmodule

// File: rtl/msched_ctrl.sv
module msched_ctrl
  import msched_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         macroValid,
  input  logic [NUM_UNITS-1:0]         macroMask,
  input  logic [NUM_UNITS*DLY_W-1:0]   macroDelays,
  input  logic [NUM_UNITS-1:0]         macroModes,
  input  logic                         instrIssued,
  output slot_ctl_t                    ctl,
  output logic [NUM_UNITS-1:0]         slotBusy,
  output logic [NUM_UNITS-1:0]         slotPend,
  output logic                         macroErr
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
    assign ctl.accept[u] = macroValid && macroMask[u] && !slotBusy[u];

    msched_slot #(.DLY_W(DLY_W)) slot_i (
      .clk       (clk),
      .rstN      (rstN),
      .load      (ctl.accept[u]),
      .delayIn   (macroDelays[u*DLY_W +: DLY_W]),
      .modeIn    (dly_mode_e'(macroModes[u])),
      .issuedTick(instrIssued),
      .busy      (slotBusy[u]),
      .pending   (slotPend[u]),
      .fire      (ctl.fire[u])
    );
  end

  assign macroErr = macroValid && |(macroMask & slotBusy);
endmodule

// File: rtl/msched_dpath.sv
module msched_dpath
  import msched_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  slot_ctl_t                        ctl,
  input  logic [NUM_UNITS*OP_W-1:0]        macroOps,
  input  logic [ADDR_W-1:0]                macroAddr,
  input  logic [NUM_UNITS-1:0]             directValid,
  input  logic [NUM_UNITS*OP_W-1:0]        directOps,
  input  logic [ADDR_W-1:0]                directAddr,
  output logic [NUM_UNITS-1:0]             unitFire,
  output logic [NUM_UNITS*OP_W-1:0]        unitOps,
  output logic [NUM_UNITS-1:0]             unitQueued,
  output logic [NUM_UNITS-1:0]             directStall,
  output logic [ADDR_W-1:0]                storeAddr,
  output logic [NUM_UNITS-1:0][OP_W-1:0]   opRegs,
  output logic [ADDR_W-1:0]                storeLatched
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        opRegs[u] <= '0;
      end else if (ctl.accept[u]) begin
        opRegs[u] <= macroOps[u*OP_W +: OP_W];
      end
    end

    // deferred slot owns the sub-unit in its firing cycle
    always_comb begin
      if (ctl.fire[u]) begin
        unitFire[u]              = 1'b1;
        unitOps[u*OP_W +: OP_W]  = opRegs[u];
        unitQueued[u]            = 1'b1;
        directStall[u]           = directValid[u];
      end else begin
        unitFire[u]              = directValid[u];
        unitOps[u*OP_W +: OP_W]  = directOps[u*OP_W +: OP_W];
        unitQueued[u]            = 1'b0;
        directStall[u]           = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeLatched <= '0;
    end else if (ctl.accept[STORE_IDX]) begin
      storeLatched <= macroAddr;
    end
  end

  assign storeAddr = ctl.fire[STORE_IDX] ? storeLatched : directAddr;
endmodule

// File: rtl/macro_slot_sched.sv
module macro_slot_sched
  import msched_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  parameter int DLY_W  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         macroValid,
  input  logic [ADDR_W-1:0]            macroAddr,
  input  logic [NUM_UNITS-1:0]         macroMask,
  input  logic [NUM_UNITS*OP_W-1:0]    macroOps,
  input  logic [NUM_UNITS*DLY_W-1:0]   macroDelays,
  input  logic [NUM_UNITS-1:0]         macroModes,
  input  logic                         instrIssued,
  input  logic [NUM_UNITS-1:0]         directValid,
  input  logic [NUM_UNITS*OP_W-1:0]    directOps,
  input  logic [ADDR_W-1:0]            directAddr,
  output logic [NUM_UNITS-1:0]         unitFire,
  output logic [NUM_UNITS*OP_W-1:0]    unitOps,
  output logic [NUM_UNITS-1:0]         unitQueued,
  output logic [NUM_UNITS-1:0]         directStall,
  output logic [ADDR_W-1:0]            storeAddr,
  output logic                         macroErr
);
  slot_ctl_t                       ctl;
  logic [NUM_UNITS-1:0]            slotBusy;
  logic [NUM_UNITS-1:0]            slotPend;
  logic [NUM_UNITS-1:0][OP_W-1:0]  opRegs;
  logic [ADDR_W-1:0]               storeLatched;

  msched_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .macroValid (macroValid),
    .macroMask  (macroMask),
    .macroDelays(macroDelays),
    .macroModes (macroModes),
    .instrIssued(instrIssued),
    .ctl        (ctl),
    .slotBusy   (slotBusy),
    .slotPend   (slotPend),
    .macroErr   (macroErr)
  );

  msched_dpath #(.OP_W(OP_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .macroOps    (macroOps),
    .macroAddr   (macroAddr),
    .directValid (directValid),
    .directOps   (directOps),
    .directAddr  (directAddr),
    .unitFire    (unitFire),
    .unitOps     (unitOps),
    .unitQueued  (unitQueued),
    .directStall (directStall),
    .storeAddr   (storeAddr),
    .opRegs      (opRegs),
    .storeLatched(storeLatched)
  );
endmodule

// File: rtl/msched_chk.sv
module msched_chk
  import msched_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  parameter int DLY_W  = 4
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             macroValid,
  input logic [NUM_UNITS-1:0]             macroMask,
  input logic [NUM_UNITS*DLY_W-1:0]       macroDelays,
  input logic [NUM_UNITS-1:0]             macroModes,
  input logic [NUM_UNITS-1:0]             directValid,
  input logic [NUM_UNITS-1:0]             directStall,
  input logic [NUM_UNITS-1:0]             unitQueued,
  input logic [NUM_UNITS-1:0]             slotBusy,
  input logic [NUM_UNITS-1:0]             slotPend,
  input logic [NUM_UNITS-1:0][OP_W-1:0]   opRegs,
  input logic [ADDR_W-1:0]                storeLatched
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    AST_STALL_ONLY_ON_QUEUED: assert property (@(posedge clk) disable iff (!rstN)
      directStall[u] |-> (unitQueued[u] && directValid[u])); // R9

    AST_QUEUED_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
      unitQueued[u] |-> slotPend[u]); // R2

    AST_ZERO_DELAY_NEXT: assert property (@(posedge clk) disable iff (!rstN)
      (macroValid && macroMask[u] && !slotBusy[u] &&
       macroDelays[u*DLY_W +: DLY_W] == '0) |=> unitQueued[u]); // R3

    AST_DELAY_ONE_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
      (macroValid && macroMask[u] && !slotBusy[u] && !macroModes[u] &&
       macroDelays[u*DLY_W +: DLY_W] == DLY_W'(1)) |=> ##1 unitQueued[u]); // R2

    AST_DROP_KEEPS_OP: assert property (@(posedge clk) disable iff (!rstN)
      (macroValid && macroMask[u] && slotBusy[u]) |=> $stable(opRegs[u])); // R7
  end

  AST_STORE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    slotBusy[STORE_IDX] |=> $stable(storeLatched)); // R6
endmodule

bind macro_slot_sched msched_chk #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .macroValid  (macroValid),
  .macroMask   (macroMask),
  .macroDelays (macroDelays),
  .macroModes  (macroModes),
  .directValid (directValid),
  .directStall (directStall),
  .unitQueued  (unitQueued),
  .slotBusy    (slotBusy),
  .slotPend    (slotPend),
  .opRegs      (opRegs),
  .storeLatched(storeLatched)
);

// File: tb/macro_slot_sched_tb_top.sv
module macro_slot_sched_tb_top;
  localparam int NU = 5;
  localparam int OW = 8;
  localparam int AW = 12;
  localparam int DW = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            macroValid = 1'b0;
  logic [AW-1:0]   macroAddr = '0;
  logic [NU-1:0]   macroMask = '0;
  logic [NU*OW-1:0] macroOps = '0;
  logic [NU*DW-1:0] macroDelays = '0;
  logic [NU-1:0]   macroModes = '0;
  logic            instrIssued = 1'b0;
  logic [NU-1:0]   directValid = '0;
  logic [NU*OW-1:0] directOps = '0;
  logic [AW-1:0]   directAddr = '0;
  logic [NU-1:0]   unitFire;
  logic [NU*OW-1:0] unitOps;
  logic [NU-1:0]   unitQueued;
  logic [NU-1:0]   directStall;
  logic [AW-1:0]   storeAddr;
  logic            macroErr;

  always #5 clk = ~clk;

  macro_slot_sched #(.OP_W(OW), .ADDR_W(AW), .DLY_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .macroValid(macroValid), .macroAddr(macroAddr),
    .macroMask(macroMask), .macroOps(macroOps), .macroDelays(macroDelays),
    .macroModes(macroModes), .instrIssued(instrIssued), .directValid(directValid),
    .directOps(directOps), .directAddr(directAddr), .unitFire(unitFire),
    .unitOps(unitOps), .unitQueued(unitQueued), .directStall(directStall),
    .storeAddr(storeAddr), .macroErr(macroErr)
  );

  typedef struct {
    int        cyc;
    int        unit;
    logic [OW-1:0] op;
    logic      q;
    logic [AW-1:0] addr;
    int        req;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic pushExp(input int c, input int u, input logic [OW-1:0] op,
                         input logic q, input logic [AW-1:0] addr, input int req);
    exp_t e;
    e.cyc = c; e.unit = u; e.op = op; e.q = q; e.addr = addr; e.req = req;
    sb.push_back(e);
  endtask

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
    macroValid = 1'b0; macroMask = '0; macroOps = '0; macroDelays = '0;
    macroModes = '0; macroAddr = '0; instrIssued = 1'b0;
    directValid = '0; directOps = '0; directAddr = '0;
  endtask

  // drives one macro in a fresh cycle; predicts fires for units in expMask
  // whose timing follows from the delay alone (cycle mode or delay 0)
  task automatic doMacro(input logic [NU-1:0] mask, input logic [NU-1:0] expMask,
                         input logic [NU-1:0] modes, input logic [NU*OW-1:0] ops,
                         input logic [NU*DW-1:0] dlys, input logic [AW-1:0] addr,
                         input logic issued, input int req);
    nextCycle();
    macroValid = 1'b1; macroMask = mask; macroModes = modes; macroOps = ops;
    macroDelays = dlys; macroAddr = addr; instrIssued = issued;
    for (int u = 0; u < NU; u++) begin
      if (expMask[u] && (!modes[u] || dlys[u*DW +: DW] == '0))
        pushExp(cyc + 1 + int'(dlys[u*DW +: DW]), u, ops[u*OW +: OW], 1'b1, addr, req);
    end
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      nextCycle();
      directAddr = 12'hFFF;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #3;
    if (rstN && !done) begin
      for (int u = 0; u < NU; u++) begin
        bit   hit;
        exp_t e;
        hit = 1'b0;
        foreach (sb[i]) if (sb[i].cyc == cyc && sb[i].unit == u) begin hit = 1'b1; e = sb[i]; end
        if (hit || unitFire[u]) begin
          nChecks++;
          if (!hit) begin
            nFails++;
            $display("FAIL unexpected fire unit %0d cycle %0d actual=%0h expected=none",
                     u, cyc, unitOps[u*OW +: OW]);
          end else if (!unitFire[u] || unitOps[u*OW +: OW] !== e.op ||
                       unitQueued[u] !== e.q || (u == NU-1 && storeAddr !== e.addr)) begin
            nFails++;
            $display("FAIL R%0d unit %0d cycle %0d actual fire=%0b op=%0h q=%0b addr=%0h expected op=%0h q=%0b addr=%0h",
                     e.req, u, cyc, unitFire[u], unitOps[u*OW +: OW], unitQueued[u], storeAddr,
                     e.op, e.q, e.addr);
          end
        end
      end
      for (int i = sb.size() - 1; i >= 0; i--) if (sb[i].cyc <= cyc) sb.delete(i);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < 3; i++) begin
      nextCycle(); #2;
      chk(1, 32'(unitFire), 32'h0);
      chk(1, 32'(directStall), 32'h0);
      chk(1, 32'(macroErr), 32'h0);
    end

    // R2: simple slot, delay 3, cycle mode
    doMacro(5'b00010, 5'b00010, 5'b0, 40'h00_00_00_11_00, 20'h0_0_0_3_0, 12'h0, 1'b0, 2);
    chk(2, 32'(macroErr), 32'h0);
    idle(6);

    // R3: delay 0 on load (cycle mode) and multiply-add (issued mode)
    doMacro(5'b00101, 5'b00101, 5'b00100, 40'h00_00_22_00_21, 20'h0, 12'h0, 1'b0, 3);
    idle(3);

    // R5, R6: three slots with different delays, store address latched
    doMacro(5'b11100, 5'b11100, 5'b0, 40'h43_42_41_00_00, 20'h2_5_1_0_0, 12'h2A5, 1'b0, 5);
    idle(7);

    // R4: issued-count mode, delay 3; the accepting edge does not count
    doMacro(5'b00010, 5'b00000, 5'b00010, 40'h00_00_00_31_00, 20'h0_0_0_3_0, 12'h0, 1'b1, 4);
    pushExp(cyc + 6, 1, 8'h31, 1'b1, 12'h0, 4);
    nextCycle(); instrIssued = 1'b0;
    nextCycle(); instrIssued = 1'b1;
    nextCycle(); instrIssued = 1'b0;
    nextCycle(); instrIssued = 1'b1;
    nextCycle(); instrIssued = 1'b1;
    idle(4);

    // R7: second macro hits the busy multiply-add slot; round still accepted
    doMacro(5'b00100, 5'b00100, 5'b0, 40'h00_00_33_00_00, 20'h0_0_4_0_0, 12'h0, 1'b0, 7);
    doMacro(5'b01100, 5'b01000, 5'b0, 40'h00_55_44_00_00, 20'h0_1_1_0_0, 12'h0, 1'b0, 7);
    chk(7, 32'(macroErr), 32'h1);
    idle(7);

    // R8, R6: store slot re-armed in its firing cycle with a new address
    doMacro(5'b10000, 5'b10000, 5'b0, 40'h61_00_00_00_00, 20'h2_0_0_0_0, 12'h0A0, 1'b0, 6);
    idle(2);
    doMacro(5'b10000, 5'b10000, 5'b0, 40'h62_00_00_00_00, 20'h0_0_0_0_0, 12'h0B0, 1'b0, 8);
    chk(8, 32'(macroErr), 32'h0);
    idle(3);

    // R9: deferred simple collides with a direct simple; direct load proceeds
    doMacro(5'b00010, 5'b00010, 5'b0, 40'h00_00_00_66_00, 20'h0_0_0_1_0, 12'h0, 1'b0, 9);
    idle(1);
    nextCycle();
    directValid = 5'b00011; directOps = 40'h00_00_00_77_78;
    pushExp(cyc, 0, 8'h78, 1'b0, 12'h0, 10);
    #2;
    chk(9, 32'(directStall), 32'h2);
    idle(2);

    // R10: direct store uses the direct address
    nextCycle();
    directValid = 5'b10000; directOps = 40'h79_00_00_00_00; directAddr = 12'h123;
    pushExp(cyc, 4, 8'h79, 1'b0, 12'h123, 10);
    #2;
    chk(10, 32'(directStall), 32'h0);
    idle(3);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule